// File: doc/BRIEF.md
# Paged PHY Management Register File

This block is the register store behind the management port of a PHY-style device. A simple access port carries a 5-bit register address, 16-bit write data, a write strobe and a read strobe. The 32 base addresses are extended by two page selectors. Address 22 holds an 8-bit page that steers addresses 0 to 21 and 23 to 28. Address 29 holds a 6-bit page that steers addresses 30 and 31. The two selectors themselves are never paged.

Each populated field follows its own access rule. The rules cover plain read/write storage, a live read-only bit, latching-high and latching-low status bits fed from status inputs, a read-clearing event counter, a writable field that clears when read, a flag that sets once it has been read, and storage that survives a software reset. The serial management framing and the PHY logic that drives the status inputs live outside this block. Read data is registered. It comes back one cycle after the read strobe and holds the value from before any side effect of that read.

Top module: `phy_page_regfile`

## Requirements
- R1: `rvalid` is high in the cycle after a cycle with `rd_en` high, and low otherwise. `rdata` carries the read value when `rvalid` is high and is zero when it is low. The value returned is the one held before any side effect of that same read.
- R2: Address 22 is the main page selector. Bits 7:0 are read/write and bits 15:8 read zero. It is reached at address 22 whatever either page holds.
- R3: Address 29 is the auxiliary page selector. Bits 5:0 are read/write and bits 15:6 read zero. It is not paged.
- R4: Addresses 0–21 and 23–28 decode through the main page. Page 0 address 0 is a 16-bit read/write control word with reset value 0x1140. Page 0 address 1 is status. Page 0 address 16 is the event counter. Page 1 address 16 is the clear-on-read word. Page 2 address 16 is the set-after-read flag. Page 3 address 16 is the retained word. Any other address on pages 0–3 reads zero and ignores writes.
- R5: Addresses 30 and 31 decode through the auxiliary page. Auxiliary page 0 address 30 is a read/write word that resets to 0. Auxiliary page 1 address 31 is a retained read/write word. The other two combinations read zero.
- R6: A main page of 4 or higher, or an auxiliary page of 2 or higher, makes its range read zero and ignore writes. Stored words on other pages stay untouched.
- R7: Status bit 1 latches high while `fault_i` is high. It stays 1 until a status read, then clears, unless `fault_i` is high in the cycle of that read, in which case it stays 1.
- R8: Status bit 2 latches low while `link_i` is low. It returns to 1 on a status read unless `link_i` is low in that cycle. Status bit 0 is the live `link_i` value.
- R9: The counter at page 0 address 16 counts cycles with `err_evt_i` high, in bits 7:0, and saturates at 255. A read returns the count and then clears it. If an event falls in the read cycle, the count becomes 1.
- R10: The word at page 1 address 16 is writable. It reads back its value once and is zero after that read.
- R11: Bit 0 at page 2 address 16 reads 0 after a reset and becomes 1 after it has been read. Writes have no effect on it.
- R12: A `soft_rst` cycle restores the control word, the auxiliary page 0 word, the clear-on-read word, the flag, the counter and both latches to their reset values. It keeps both page selectors and both retained words. Writes in that cycle are ignored.
- R13: After a hardware reset (`rst_n` low), every field holds its reset value, `rvalid` is low and `rdata` is zero. Status reads 0x0005 when `link_i` is high and `fault_i` is low.
- R14: When `wr_en` and `rd_en` are both high in one cycle, the read returns the old value and the write is stored. A write wins over a clear caused by the same read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Software reset, one-cycle synchronous pulse |
| addr | input | 5 | Register address |
| wdata | input | 16 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| fault_i | input | 1 | Status input feeding the latching-high bit |
| link_i | input | 1 | Status input feeding the latching-low bit and the live bit |
| err_evt_i | input | 1 | Event input of the saturating counter |
| rdata | output | 16 | Registered read data |
| rvalid | output | 1 | Read data valid |

## Verification
Every read result is due exactly one clock edge after the cycle that carries `rd_en`. Every side effect of an access or a status input is due at the same edge. That covers latch set or release, counter clear, flag set, page change and soft-reset restore. The bench drives each access on a falling edge, so the next rising edge both returns the read and commits the effects. It samples one time unit after that edge. Its reference state is updated with exactly one step per driven cycle, so a pre-clear value and a post-clear value are never confused.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] MAIN_PG_ADDR = 5'd22;
    localparam logic [ADDR_W-1:0] AUX_PG_ADDR  = 5'd29;
    localparam logic [ADDR_W-1:0] AUX_FIRST    = 5'd30;
    localparam logic [ADDR_W-1:0] AUX_SECOND   = 5'd31;
    localparam logic [ADDR_W-1:0] CTRL_ADDR    = 5'd0;
    localparam logic [ADDR_W-1:0] STAT_ADDR    = 5'd1;
    localparam logic [ADDR_W-1:0] EXT_ADDR     = 5'd16;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_PG_MAIN,
        SEL_PG_AUX,
        SEL_CTRL,
        SEL_STAT,
        SEL_CNT,
        SEL_RWC,
        SEL_ROS,
        SEL_RET,
        SEL_AUX0,
        SEL_AUX1
    } reg_sel_e;

endpackage

// File: rtl/phy_page_decode.sv
module phy_page_decode
    import phy_mgmt_pkg::*;
#(
    parameter int MAIN_PG_W  = 8,
    parameter int AUX_PG_W   = 6,
    parameter int MAIN_PAGES = 4,
    parameter int AUX_PAGES  = 2
) (
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [MAIN_PG_W-1:0] main_pg_i,
    input  logic [AUX_PG_W-1:0]  aux_pg_i,
    output reg_sel_e             sel_o
);

    localparam logic [MAIN_PG_W-1:0] MAIN_LIM = MAIN_PG_W'(MAIN_PAGES);
    localparam logic [AUX_PG_W-1:0]  AUX_LIM  = AUX_PG_W'(AUX_PAGES);

    always_comb begin
        sel_o = SEL_NONE;
        if (addr_i == MAIN_PG_ADDR) begin
            sel_o = SEL_PG_MAIN;
        end else if (addr_i == AUX_PG_ADDR) begin
            sel_o = SEL_PG_AUX;
        end else if (addr_i >= AUX_FIRST) begin
            if (aux_pg_i < AUX_LIM) begin
                if (aux_pg_i == AUX_PG_W'(0) && addr_i == AUX_FIRST) begin
                    sel_o = SEL_AUX0;
                end else if (aux_pg_i == AUX_PG_W'(1) && addr_i == AUX_SECOND) begin
                    sel_o = SEL_AUX1;
                end
            end
        end else if (main_pg_i < MAIN_LIM) begin
            unique case (main_pg_i)
                MAIN_PG_W'(0): begin
                    if (addr_i == CTRL_ADDR)      sel_o = SEL_CTRL;
                    else if (addr_i == STAT_ADDR) sel_o = SEL_STAT;
                    else if (addr_i == EXT_ADDR)  sel_o = SEL_CNT;
                end
                MAIN_PG_W'(1): if (addr_i == EXT_ADDR) sel_o = SEL_RWC;
                MAIN_PG_W'(2): if (addr_i == EXT_ADDR) sel_o = SEL_ROS;
                MAIN_PG_W'(3): if (addr_i == EXT_ADDR) sel_o = SEL_RET;
                default: sel_o = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/phy_latch_bit.sv
module phy_latch_bit #(
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_rst,
    input  logic status_i,
    input  logic release_i,
    output logic q_o
);

    localparam logic IDLE_VAL = !ACTIVE_HIGH;
    localparam logic HIT_VAL  = ACTIVE_HIGH;

    logic q_d, q_q;
    logic hit;

    assign hit = (status_i == HIT_VAL);

    always_comb begin
        q_d = q_q;
        if (soft_rst) begin
            q_d = IDLE_VAL;
        end else if (hit) begin
            q_d = HIT_VAL;
        end else if (release_i) begin
            q_d = IDLE_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= IDLE_VAL;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

endmodule

// File: rtl/phy_event_counter.sv
module phy_event_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             evt_i,
    input  logic             rd_clear_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (soft_rst) begin
            cnt_d = '0;
        end else if (rd_clear_i) begin
            cnt_d = CNT_W'(evt_i);
        end else if (evt_i && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/phy_page_regfile.sv
module phy_page_regfile
    import phy_mgmt_pkg::*;
#(
    parameter int              DATA_W     = 16,
    parameter int              MAIN_PG_W  = 8,
    parameter int              AUX_PG_W   = 6,
    parameter int              MAIN_PAGES = 4,
    parameter int              AUX_PAGES  = 2,
    parameter int              CNT_W      = 8,
    parameter logic [DATA_W-1:0] CTRL_RST = 'h1140
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic [4:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              fault_i,
    input  logic              link_i,
    input  logic              err_evt_i,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    localparam int N_LATCH = 2;
    localparam logic [N_LATCH-1:0] LATCH_POL = 2'b01; // bit0 latches high, bit1 latches low

    typedef struct packed {
        logic [MAIN_PG_W-1:0] main_pg;
        logic [AUX_PG_W-1:0]  aux_pg;
        logic [DATA_W-1:0]    ctrl;
        logic [DATA_W-1:0]    rwc;
        logic [DATA_W-1:0]    ret;
        logic [DATA_W-1:0]    aux0;
        logic [DATA_W-1:0]    aux1;
        logic [DATA_W-1:0]    rdata;
        logic                 ros;
        logic                 rvalid;
    } state_t;

    state_t d, q;

    reg_sel_e          sel;
    logic [N_LATCH-1:0] latch_q;
    logic [N_LATCH-1:0] latch_in;
    logic [CNT_W-1:0]  evt_cnt;
    logic              rd_stat;
    logic              rd_cnt;
    logic [DATA_W-1:0] rd_val;

    phy_page_decode #(
        .MAIN_PG_W (MAIN_PG_W),
        .AUX_PG_W  (AUX_PG_W),
        .MAIN_PAGES(MAIN_PAGES),
        .AUX_PAGES (AUX_PAGES)
    ) i_decode (
        .addr_i   (addr),
        .main_pg_i(q.main_pg),
        .aux_pg_i (q.aux_pg),
        .sel_o    (sel)
    );

    assign rd_stat  = rd_en && (sel == SEL_STAT);
    assign rd_cnt   = rd_en && (sel == SEL_CNT);
    assign latch_in = {link_i, fault_i};

    for (genvar g = 0; g < N_LATCH; g++) begin : g_latch
        phy_latch_bit #(
            .ACTIVE_HIGH(LATCH_POL[g])
        ) i_latch (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .status_i (latch_in[g]),
            .release_i(rd_stat),
            .q_o      (latch_q[g])
        );
    end

    phy_event_counter #(
        .CNT_W(CNT_W)
    ) i_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .evt_i     (err_evt_i),
        .rd_clear_i(rd_cnt),
        .cnt_o     (evt_cnt)
    );

    // read multiplexer: value before any side effect of the current access
    always_comb begin
        rd_val = '0;
        unique case (sel)
            SEL_PG_MAIN: rd_val = DATA_W'(q.main_pg);
            SEL_PG_AUX:  rd_val = DATA_W'(q.aux_pg);
            SEL_CTRL:    rd_val = q.ctrl;
            SEL_STAT:    rd_val = DATA_W'({latch_q[1], latch_q[0], link_i});
            SEL_CNT:     rd_val = DATA_W'(evt_cnt);
            SEL_RWC:     rd_val = q.rwc;
            SEL_ROS:     rd_val = DATA_W'(q.ros);
            SEL_RET:     rd_val = q.ret;
            SEL_AUX0:    rd_val = q.aux0;
            SEL_AUX1:    rd_val = q.aux1;
            default:     rd_val = '0;
        endcase
    end

    always_comb begin
        d        = q;
        d.rvalid = rd_en;
        d.rdata  = rd_en ? rd_val : '0;
        if (soft_rst) begin
            d.ctrl = CTRL_RST;
            d.rwc  = '0;
            d.ros  = 1'b0;
            d.aux0 = '0;
        end else begin
            if (rd_en && sel == SEL_RWC) d.rwc = '0;
            if (rd_en && sel == SEL_ROS) d.ros = 1'b1;
            if (wr_en) begin
                unique case (sel)
                    SEL_PG_MAIN: d.main_pg = wdata[MAIN_PG_W-1:0];
                    SEL_PG_AUX:  d.aux_pg  = wdata[AUX_PG_W-1:0];
                    SEL_CTRL:    d.ctrl    = wdata;
                    SEL_RWC:     d.rwc     = wdata;
                    SEL_RET:     d.ret     = wdata;
                    SEL_AUX0:    d.aux0    = wdata;
                    SEL_AUX1:    d.aux1    = wdata;
                    default:     d.ctrl    = q.ctrl;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.ctrl    <= CTRL_RST;
        end else begin
            q <= d;
        end
    end

    assign rdata  = q.rdata;
    assign rvalid = q.rvalid;

endmodule

// File: rtl/phy_page_regfile_chk.sv
module phy_page_regfile_chk #(
    parameter int DATA_W     = 16,
    parameter int MAIN_PG_W  = 8,
    parameter int MAIN_PAGES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              soft_rst,
    input logic [4:0]        addr,
    input logic              rd_en,
    input logic              fault_i,
    input logic              link_i,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic [MAIN_PG_W-1:0] main_pg_q,
    input logic              lh_q,
    input logic              ll_q,
    input logic [DATA_W-1:0] ret_q
);

    logic main_range;
    assign main_range = (addr != 5'd22) && (addr != 5'd29) && (addr < 5'd30);

    assert_read_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rvalid && rdata == '0));

    assert_main_pg_rsvd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 5'd22) |=> (rdata[DATA_W-1:8] == '0));

    assert_aux_pg_rsvd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 5'd29) |=> (rdata[DATA_W-1:6] == '0));

    assert_unimpl_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && main_range && main_pg_q >= MAIN_PG_W'(MAIN_PAGES)) |=> (rdata == '0));

    assert_latch_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_i && !soft_rst) |=> lh_q);

    assert_latch_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_i && !soft_rst) |=> !ll_q);

    assert_retain_R12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> $stable(ret_q));

endmodule

bind phy_page_regfile phy_page_regfile_chk #(
    .DATA_W    (DATA_W),
    .MAIN_PG_W (MAIN_PG_W),
    .MAIN_PAGES(MAIN_PAGES)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_rst (soft_rst),
    .addr     (addr),
    .rd_en    (rd_en),
    .fault_i  (fault_i),
    .link_i   (link_i),
    .rdata    (rdata),
    .rvalid   (rvalid),
    .main_pg_q(q.main_pg),
    .lh_q     (latch_q[0]),
    .ll_q     (latch_q[1]),
    .ret_q    (q.ret)
);

// File: tb/test_phy_page_regfile.sv
module test_phy_page_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        fault_i = 1'b0;
    logic        link_i = 1'b1;
    logic        err_evt_i = 1'b0;
    logic [15:0] rdata;
    logic        rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // status inputs applied by each step
    bit st_flt = 1'b0;
    bit st_lnk = 1'b1;
    bit st_evt = 1'b0;

    // reference state
    logic [7:0]  m_pg22;
    logic [5:0]  m_pg29;
    logic [15:0] m_ctrl, m_rwc, m_ret, m_aux0, m_aux1;
    logic [7:0]  m_cnt;
    bit          m_ros, m_lh, m_ll;

    always #5 clk = ~clk;

    phy_page_regfile i_phy_page_regfile (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .addr     (addr),
        .wdata    (wdata),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .fault_i  (fault_i),
        .link_i   (link_i),
        .err_evt_i(err_evt_i),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // 0 none,1 page22,2 page29,3 ctrl,4 status,5 counter,6 clr-on-read,7 set-after-read,8 retained,9 aux0,10 aux1
    function automatic int bsel(input logic [4:0] a);
        if (a == 5'd22) return 1;
        if (a == 5'd29) return 2;
        if (a >= 5'd30) begin
            if (m_pg29 == 6'd0 && a == 5'd30) return 9;
            if (m_pg29 == 6'd1 && a == 5'd31) return 10;
            return 0;
        end
        case (m_pg22)
            8'd0: begin
                if (a == 5'd0)  return 3;
                if (a == 5'd1)  return 4;
                if (a == 5'd16) return 5;
            end
            8'd1: if (a == 5'd16) return 6;
            8'd2: if (a == 5'd16) return 7;
            8'd3: if (a == 5'd16) return 8;
            default: return 0;
        endcase
        return 0;
    endfunction

    function automatic logic [15:0] bread(input int s);
        case (s)
            1:  return {8'h00, m_pg22};
            2:  return {10'h000, m_pg29};
            3:  return m_ctrl;
            4:  return {13'h0, m_ll, m_lh, st_lnk};
            5:  return {8'h00, m_cnt};
            6:  return m_rwc;
            7:  return {15'h0, m_ros};
            8:  return m_ret;
            9:  return m_aux0;
            10: return m_aux1;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string btag(input int s);
        case (s)
            1: return "R2";
            2: return "R3";
            3, 8: return "R4";
            4: return "R7 R8";
            5: return "R9";
            6: return "R10";
            7: return "R11";
            9, 10: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic model_reset();
        m_pg22 = '0; m_pg29 = '0; m_ctrl = 16'h1140; m_rwc = '0; m_ret = '0;
        m_aux0 = '0; m_aux1 = '0; m_cnt = '0; m_ros = 0; m_lh = 0; m_ll = 1;
    endtask

    task automatic step(input logic [4:0] a, input logic [15:0] wd, input bit wr,
                        input bit rd, input bit srst, input string req);
        int s;
        logic [15:0] exp;
        @(negedge clk);
        addr = a; wdata = wd; wr_en = wr; rd_en = rd; soft_rst = srst;
        fault_i = st_flt; link_i = st_lnk; err_evt_i = st_evt;
        s   = bsel(a);
        exp = bread(s);
        // latches and counter
        if (srst) m_lh = 0; else if (st_flt) m_lh = 1; else if (rd && s == 4) m_lh = 0;
        if (srst) m_ll = 1; else if (!st_lnk) m_ll = 0; else if (rd && s == 4) m_ll = 1;
        if (srst) m_cnt = 0;
        else if (rd && s == 5) m_cnt = st_evt ? 8'd1 : 8'd0;
        else if (st_evt && m_cnt != 8'd255) m_cnt = m_cnt + 8'd1;
        if (srst) begin
            m_ctrl = 16'h1140; m_rwc = '0; m_ros = 0; m_aux0 = '0;
        end else begin
            if (rd && s == 6) m_rwc = '0;
            if (rd && s == 7) m_ros = 1;
            if (wr) begin
                case (s)
                    1:  m_pg22 = wd[7:0];
                    2:  m_pg29 = wd[5:0];
                    3:  m_ctrl = wd;
                    6:  m_rwc  = wd;
                    8:  m_ret  = wd;
                    9:  m_aux0 = wd;
                    10: m_aux1 = wd;
                    default: ;
                endcase
            end
        end
        @(posedge clk);
        #1;
        if (rd) begin
            chk("R1", {15'h0, rvalid}, 16'h0001);
            chk((req.len() != 0) ? req : btag(s), rdata, exp);
        end else begin
            chk("R1", {rdata[14:0], rvalid}, 16'h0000);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        step(a, d, 1, 0, 0, "");
    endtask

    task automatic rd_reg(input logic [4:0] a, input string req);
        step(a, 16'h0, 0, 1, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(posedge clk);
        #1;
        chk("R13", {rdata[14:0], rvalid}, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;

        // R13 reset values
        rd_reg(5'd1, "R13");
        rd_reg(5'd0, "R13");
        rd_reg(5'd22, "R13");
        rd_reg(5'd16, "R13");

        // R2 R3 page selectors and reserved bits
        wr_reg(5'd22, 16'hFF03);
        rd_reg(5'd22, "R2");
        wr_reg(5'd16, 16'hBEEF);
        rd_reg(5'd16, "R4");
        wr_reg(5'd29, 16'hFFC1);
        rd_reg(5'd29, "R3");
        wr_reg(5'd31, 16'h5A5A);
        rd_reg(5'd31, "R5");
        rd_reg(5'd30, "R5");

        // R6 unimplemented page, then the stored word is untouched
        wr_reg(5'd22, 16'h0005);
        wr_reg(5'd16, 16'hAAAA);
        rd_reg(5'd16, "R6");
        rd_reg(5'd22, "R2");
        wr_reg(5'd22, 16'h0003);
        rd_reg(5'd16, "R6");

        // R7 latch high with event in the read cycle
        wr_reg(5'd22, 16'h0000);
        st_flt = 1; step(5'd0, 0, 0, 0, 0, "");
        rd_reg(5'd1, "R7");
        st_flt = 0;
        rd_reg(5'd1, "R7");
        rd_reg(5'd1, "R7");

        // R8 latch low
        st_lnk = 0; step(5'd0, 0, 0, 0, 0, "");
        st_lnk = 1;
        rd_reg(5'd1, "R8");
        rd_reg(5'd1, "R8");

        // R9 counter saturation and clear
        st_evt = 1;
        repeat (300) step(5'd0, 0, 0, 0, 0, "");
        st_evt = 0;
        rd_reg(5'd16, "R9");
        rd_reg(5'd16, "R9");
        st_evt = 1; step(5'd0, 0, 0, 0, 0, "");
        rd_reg(5'd16, "R9");
        st_evt = 0;
        rd_reg(5'd16, "R9");

        // R10 clear-on-read word
        wr_reg(5'd22, 16'h0001);
        wr_reg(5'd16, 16'h1234);
        rd_reg(5'd16, "R10");
        rd_reg(5'd16, "R10");

        // R11 set-after-read flag, writes ignored
        wr_reg(5'd22, 16'h0002);
        wr_reg(5'd16, 16'hFFFF);
        rd_reg(5'd16, "R11");
        rd_reg(5'd16, "R11");

        // R14 read and write in one cycle
        wr_reg(5'd22, 16'h0001);
        wr_reg(5'd16, 16'h0F0F);
        step(5'd16, 16'h7777, 1, 1, 0, "R14");
        rd_reg(5'd16, "R14");

        // R12 soft reset
        wr_reg(5'd22, 16'h0000);
        wr_reg(5'd0, 16'h2222);
        wr_reg(5'd29, 16'h0000);
        wr_reg(5'd30, 16'h3333);
        st_flt = 1; step(5'd0, 0, 0, 0, 0, ""); st_flt = 0;
        step(5'd0, 16'h9999, 1, 0, 1, "");
        rd_reg(5'd0, "R12");
        rd_reg(5'd1, "R12");
        rd_reg(5'd30, "R12");
        rd_reg(5'd22, "R12");
        wr_reg(5'd22, 16'h0003);
        rd_reg(5'd16, "R12");
        wr_reg(5'd29, 16'h0001);
        rd_reg(5'd31, "R12");

        // constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [4:0]  a;
            logic [15:0] d;
            int pick;
            bit wr, rd, sr;
            pick = int'($urandom_range(0, 9));
            case (pick)
                0: a = 5'd0;
                1: a = 5'd1;
                2, 3: a = 5'd16;
                4: a = 5'd22;
                5: a = 5'd29;
                6: a = 5'd30;
                7: a = 5'd31;
                default: a = 5'($urandom_range(0, 31));
            endcase
            d = 16'($urandom);
            if (a == 5'd22) d[7:0] = 8'($urandom_range(0, 5));
            if (a == 5'd29) d[5:0] = 6'($urandom_range(0, 2));
            wr = ($urandom_range(0, 2) == 0);
            rd = ($urandom_range(0, 1) == 0);
            sr = ($urandom_range(0, 63) == 0);
            st_flt = ($urandom_range(0, 7) == 0);
            st_lnk = ($urandom_range(0, 5) != 0);
            st_evt = ($urandom_range(0, 3) == 0);
            step(a, d, wr, rd, sr, "");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule